// File: doc/BRIEF.md
# Packed FP8 to FP32 Widening Decoder

This block takes a 64-bit word that carries eight independent 8-bit floating-point values and widens every one of them to an IEEE single-precision word. All lanes share one format selection, chosen at run time from four exponent/mantissa splits. A second control bit decides whether the 4-exponent-bit format spends its all-ones exponent on extra finite values or reserves it for infinity and NaN. Each lane produces a 32-bit result and four class flags: NaN, infinity, zero and subnormal input.

Widening is exact, so the block never rounds. Subnormal inputs are renormalised into FP32 normal numbers with a leading-one search over the fraction. Every NaN is replaced by the canonical quiet NaN, and its sign is kept. An output register stage can be included by parameter. When it is included, the format controls are captured in the same cycle as the data, and the result appears one cycle later with a valid strobe.

Top module: `fp8w_decoder`

## Requirements
- R1: `in_fmt` selects the split with 1 sign bit in bit 7: 0 = 5 exponent/2 fraction bits (bias 15), 1 = 4/3 (bias 7), 2 = 3/4 (bias 3), 3 = 2/5 (bias 1). In format 0, a nonzero exponent field E that is not all ones with fraction F gives (-1)^s·2^(E−15)·(1+F/4), exactly as an FP32 normal.
- R2: In formats 1, 2 and 3, a nonzero, non-reserved exponent field gives (-1)^s·2^(E−bias)·(1+F/2^m) exactly, where m is the fraction width.
- R3: A zero exponent field with a nonzero fraction gives (-1)^s·2^(1−bias)·F/2^m as a normalised FP32 value (nonzero FP32 exponent) and raises the subnormal flag.
- R4: A zero exponent field with a zero fraction gives a signed FP32 zero and raises the zero flag.
- R5: In format 0, the all-ones exponent field gives signed infinity (0x7F800000 plus sign) when the fraction is zero and NaN otherwise.
- R6: In format 1 with `in_ext_range`=1, the all-ones exponent field holds normal values. The only exception is the all-ones fraction, which is NaN. Byte 0x7E decodes to 448 (0x43E00000).
- R7: In format 1 with `in_ext_range`=0, the all-ones exponent field is treated as in R5.
- R8: In formats 2 and 3, the all-ones exponent field is reserved and treated as in R5. The largest finite values are 15.5 and 3.9375 (byte 0x5F in format 3 gives 0x407C0000). `in_ext_range` has no effect outside format 1.
- R9: Every NaN output is 0x7FC00000 with the input sign in bit 31.
- R10: At most one of the four lane flags is set for any input.
- R11: Lane i reads input bits [8i+7:8i] and drives output bits [32i+31:32i] and flag bit i, independently of the other lanes.
- R12: With the output register in place, a word presented with `in_valid` is shown one cycle later with `out_valid` high. Outputs hold while `in_valid` is low, and reset clears all outputs and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word and controls are valid |
| in_fmt | input | 2 | Exponent/mantissa split shared by all lanes |
| in_ext_range | input | 1 | 1: all-ones exponent is finite in format 1 |
| in_data | input | LANES*8 | Packed FP8 lanes |
| out_valid | output | 1 | Result valid |
| out_data | output | LANES*32 | Packed FP32 results |
| out_nan | output | LANES | Per-lane NaN flag |
| out_inf | output | LANES | Per-lane infinity flag |
| out_zero | output | LANES | Per-lane zero flag |
| out_sub | output | LANES | Per-lane subnormal-input flag |

## Verification
The bench builds two copies with the default eight lanes: one with the output register (OUT_REG=1) and one without it (OUT_REG=0). Both copies are fed the same stimulus. The unregistered copy is sampled shortly after the inputs change. The registered copy brings the one-cycle latency, the hold while `in_valid` is low, and the reset state within reach. Eight lanes let all 256 byte codes of a format go through in 32 words, so every format is swept exhaustively under both settings of `in_ext_range`. Seeded random words follow the sweep.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

    typedef enum logic [1:0] {
        FMT_E5M2 = 2'd0,
        FMT_E4M3 = 2'd1,
        FMT_E3M4 = 2'd2,
        FMT_E2M5 = 2'd3
    } fp8w_fmt_e;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int FRAC8_W = 5;   // widest fraction, left-aligned
    localparam int F32_BIAS = 127;

    localparam logic [30:0] F32_QNAN_MAG = 31'h7FC0_0000;
    localparam logic [30:0] F32_INF_MAG  = 31'h7F80_0000;

    typedef struct packed {
        logic                 sign;
        logic [4:0]           exp_f;   // zero-extended exponent field
        logic [FRAC8_W-1:0]   frac;    // fraction aligned to the MSB
    } fp8w_fields_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              nan;
        logic              inf;
        logic              zero;
        logic              sub;
    } fp8w_lane_t;

    function automatic logic [7:0] fmt_bias(fp8w_fmt_e f);
        case (f)
            FMT_E5M2: return 8'd15;
            FMT_E4M3: return 8'd7;
            FMT_E3M4: return 8'd3;
            default:  return 8'd1;
        endcase
    endfunction

    function automatic logic [4:0] fmt_exp_top(fp8w_fmt_e f);
        case (f)
            FMT_E5M2: return 5'd31;
            FMT_E4M3: return 5'd15;
            FMT_E3M4: return 5'd7;
            default:  return 5'd3;
        endcase
    endfunction

    function automatic logic [FRAC8_W-1:0] fmt_frac_mask(fp8w_fmt_e f);
        case (f)
            FMT_E5M2: return 5'b11000;
            FMT_E4M3: return 5'b11100;
            FMT_E3M4: return 5'b11110;
            default:  return 5'b11111;
        endcase
    endfunction

endpackage

// File: rtl/fp8w_unpack.sv
module fp8w_unpack
    import fp8w_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    input  fp8w_fmt_e         fmt,
    output fp8w_fields_t      fields
);
    always_comb begin
        fields.sign = in_byte[7];
        case (fmt)
            FMT_E5M2: begin
                fields.exp_f = in_byte[6:2];
                fields.frac  = {in_byte[1:0], 3'b000};
            end
            FMT_E4M3: begin
                fields.exp_f = {1'b0, in_byte[6:3]};
                fields.frac  = {in_byte[2:0], 2'b00};
            end
            FMT_E3M4: begin
                fields.exp_f = {2'b00, in_byte[6:4]};
                fields.frac  = {in_byte[3:0], 1'b0};
            end
            default: begin
                fields.exp_f = {3'b000, in_byte[6:5]};
                fields.frac  = in_byte[4:0];
            end
        endcase
    end
endmodule

// File: rtl/fp8w_norm.sv
module fp8w_norm
    import fp8w_pkg::*;
(
    input  logic [FRAC8_W-1:0] frac,
    output logic [2:0]         shift,
    output logic [FRAC8_W-1:0] mant
);
    logic [FRAC8_W:0] shifted;

    // leading-one search: highest set bit wins
    always_comb begin
        shift = 3'(FRAC8_W);
        for (int i = 0; i < FRAC8_W; i++) begin
            if (frac[i]) shift = 3'(FRAC8_W - i);
        end
        shifted = {1'b0, frac} << shift;
        mant    = shifted[FRAC8_W-1:0];   // hidden one falls off the top
    end
endmodule

// File: rtl/fp8w_lane.sv
module fp8w_lane
    import fp8w_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    input  fp8w_fmt_e         fmt,
    input  logic              ext_range,
    output fp8w_lane_t        res
);
    fp8w_fields_t       fld;
    logic [2:0]         nshift;
    logic [FRAC8_W-1:0] nmant;
    logic [7:0]         bias;
    logic               exp_top, exp_zero, frac_zero, frac_full, top_finite;
    logic [7:0]         exp_norm, exp_sub;

    fp8w_unpack u_unpack (.in_byte(in_byte), .fmt(fmt), .fields(fld));
    fp8w_norm   u_norm   (.frac(fld.frac), .shift(nshift), .mant(nmant));

    always_comb begin
        bias       = fmt_bias(fmt);
        exp_top    = (fld.exp_f == fmt_exp_top(fmt));
        exp_zero   = (fld.exp_f == 5'd0);
        frac_zero  = (fld.frac == '0);
        frac_full  = (fld.frac == fmt_frac_mask(fmt));
        top_finite = (fmt == FMT_E4M3) && ext_range;

        res.nan  = exp_top && (top_finite ? frac_full : !frac_zero);
        res.inf  = exp_top && !top_finite && frac_zero;
        res.zero = exp_zero && frac_zero;
        res.sub  = exp_zero && !frac_zero;

        exp_norm = {3'b000, fld.exp_f} + 8'(F32_BIAS) - bias;
        exp_sub  = 8'(F32_BIAS + 1) - bias - {5'b00000, nshift};

        if (res.nan)
            res.word = {fld.sign, F32_QNAN_MAG};
        else if (res.inf)
            res.word = {fld.sign, F32_INF_MAG};
        else if (res.zero)
            res.word = {fld.sign, 31'd0};
        else if (res.sub)
            res.word = {fld.sign, exp_sub, nmant, 18'd0};
        else
            res.word = {fld.sign, exp_norm, fld.frac, 18'd0};
    end

    always_comb begin
        AST_FLAGS_ONEHOT: assert ($onehot0({res.nan, res.inf, res.zero, res.sub})); // R10
        if (res.nan)
            AST_NAN_CANON: assert (res.word[30:0] == F32_QNAN_MAG); // R9
        if (res.inf)
            AST_INF_CODE: assert (res.word[30:0] == F32_INF_MAG); // R5
        if (res.zero)
            AST_ZERO_CODE: assert (res.word[30:0] == 31'd0); // R4
        if (res.sub)
            AST_SUB_NORMALISED: assert (res.word[30:23] != 8'd0 && res.word[30:23] != 8'hFF); // R3
    end
endmodule

// File: rtl/fp8w_decoder.sv
module fp8w_decoder
    import fp8w_pkg::*;
#(
    parameter int LANES   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               in_fmt,
    input  logic                     in_ext_range,
    input  logic [LANES*BYTE_W-1:0]  in_data,
    output logic                     out_valid,
    output logic [LANES*WORD_W-1:0]  out_data,
    output logic [LANES-1:0]         out_nan,
    output logic [LANES-1:0]         out_inf,
    output logic [LANES-1:0]         out_zero,
    output logic [LANES-1:0]         out_sub
);
    localparam int OUT_W = LANES * WORD_W;

    fp8w_fmt_e          fmt;
    fp8w_lane_t         lane_res [LANES];
    logic [OUT_W-1:0]   c_data;
    logic [LANES-1:0]   c_nan, c_inf, c_zero, c_sub;

    assign fmt = fp8w_fmt_e'(in_fmt);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fp8w_lane u_lane (
            .in_byte   (in_data[g*BYTE_W +: BYTE_W]),
            .fmt       (fmt),
            .ext_range (in_ext_range),
            .res       (lane_res[g])
        );
        assign c_data[g*WORD_W +: WORD_W] = lane_res[g].word;
        assign c_nan[g]  = lane_res[g].nan;
        assign c_inf[g]  = lane_res[g].inf;
        assign c_zero[g] = lane_res[g].zero;
        assign c_sub[g]  = lane_res[g].sub;

        AST_LANE_NAN_OUT: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_nan[g]) |-> (out_data[g*WORD_W +: 31] == F32_QNAN_MAG)); // R9
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_data  <= '0;
                out_nan   <= '0;
                out_inf   <= '0;
                out_zero  <= '0;
                out_sub   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_data <= c_data;
                    out_nan  <= c_nan;
                    out_inf  <= c_inf;
                    out_zero <= c_zero;
                    out_sub  <= c_sub;
                end
            end
        end

        AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R12
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(out_data) && !out_valid)); // R12
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = c_data;
        assign out_nan   = c_nan;
        assign out_inf   = c_inf;
        assign out_zero  = c_zero;
        assign out_sub   = c_sub;
    end
endmodule

// File: tb/tb_fp8w_decoder.sv
`timescale 1ns/1ps
module tb_fp8w_decoder;
    localparam int LN = 8;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ext;
    logic [1:0] in_fmt;
    logic [LN*8-1:0] in_data;

    logic r_valid, c_valid;
    logic [LN*32-1:0] r_data, c_data;
    logic [LN-1:0] r_nan, r_inf, r_zero, r_sub;
    logic [LN-1:0] c_nan, c_inf, c_zero, c_sub;

    int checks = 0;
    int errors = 0;

    logic [31:0] ew [LN];
    logic [3:0]  ef [LN];
    string       et [LN];

    always #2 clk = ~clk;

    fp8w_decoder #(.LANES(LN), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_ext_range(in_ext), .in_data(in_data), .out_valid(r_valid),
        .out_data(r_data), .out_nan(r_nan), .out_inf(r_inf),
        .out_zero(r_zero), .out_sub(r_sub));

    fp8w_decoder #(.LANES(LN), .OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_ext_range(in_ext), .in_data(in_data), .out_valid(c_valid),
        .out_data(c_data), .out_nan(c_nan), .out_inf(c_inf),
        .out_zero(c_zero), .out_sub(c_sub));

    // Reference: value = sig * 2^e0, then normalised by a bit search
    function automatic void ref_lane(input logic [7:0] b, input int fmt, input bit ext,
                                     output logic [31:0] w, output logic [3:0] fl,
                                     output string tag);
        int eb, mb, bias, e, f, top, sig, e0, k;
        bit s;
        eb = 5 - fmt;
        mb = 7 - eb;
        bias = (1 << (eb - 1)) - 1;
        e = (int'(b) >> mb) & ((1 << eb) - 1);
        f = int'(b) & ((1 << mb) - 1);
        top = (1 << eb) - 1;
        s = b[7];
        fl = 4'b0000;
        tag = (fmt == 0) ? "R1" : "R2";
        if (e == top && !(fmt == 1 && ext)) begin
            if (f == 0) begin
                w = {s, 31'h7F800000}; fl = 4'b0100;
                tag = (fmt == 0) ? "R5" : (fmt == 1) ? "R7" : "R8";
            end else begin
                w = {s, 31'h7FC00000}; fl = 4'b1000; tag = "R9";
            end
            return;
        end
        if (e == top && f == (1 << mb) - 1) begin
            w = {s, 31'h7FC00000}; fl = 4'b1000; tag = "R9";
            return;
        end
        if (e == top) tag = "R6";
        if (e == 0 && f == 0) begin
            w = {s, 31'd0}; fl = 4'b0010; tag = "R4";
            return;
        end
        if (e == 0) begin
            sig = f; e0 = 1 - bias - mb; fl = 4'b0001; tag = "R3";
        end else begin
            sig = (1 << mb) | f; e0 = e - bias - mb;
        end
        k = 0;
        for (int i = 0; i < 8; i++) if ((sig >> i) & 1) k = i;
        w = {s, 8'(e0 + k + 127), 23'((sig << (23 - k)) & 32'h7FFFFF)};
    endfunction

    task automatic check_set(input string which, input logic [LN*32-1:0] d,
                             input logic [LN-1:0] n, input logic [LN-1:0] i,
                             input logic [LN-1:0] z, input logic [LN-1:0] s);
        for (int l = 0; l < LN; l++) begin
            logic [3:0] af;
            af = {n[l], i[l], z[l], s[l]};
            checks++;
            if (d[l*32 +: 32] !== ew[l] || af !== ef[l]) begin
                errors++;
                $display("FAIL %s %s lane %0d (R11,R10) word=%h exp=%h flags=%b exp=%b",
                         et[l], which, l, d[l*32 +: 32], ew[l], af, ef[l]);
            end
        end
    endtask

    task automatic apply(input logic [LN*8-1:0] w, input int fmt, input bit ext);
        in_data = w; in_fmt = 2'(fmt); in_ext = ext; in_valid = 1'b1;
        for (int l = 0; l < LN; l++) ref_lane(w[l*8 +: 8], fmt, ext, ew[l], ef[l], et[l]);
        #1;
        check_set("comb", c_data, c_nan, c_inf, c_zero, c_sub);
        @(negedge clk);
        check_set("reg", r_data, r_nan, r_inf, r_zero, r_sub);
        checks++;
        if (r_valid !== 1'b1) begin
            errors++;
            $display("FAIL R12 out_valid=%b exp=1", r_valid);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s word=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7731);
        rst = 1'b1; in_valid = 1'b0; in_fmt = 2'd0; in_ext = 1'b0;
        in_data = 64'hDEAD_BEEF_0123_4567;
        repeat (3) @(negedge clk);
        checks++;
        if (r_valid !== 1'b0 || r_data !== '0 || r_nan !== '0) begin
            errors++;
            $display("FAIL R12 reset valid=%b data=%h exp=0", r_valid, r_data);
        end
        rst = 1'b0;

        // explicit boundary values
        apply(64'h0000_0000_0000_007E, 1, 1'b1);
        check_word("R6", r_data[31:0], 32'h43E0_0000);
        apply(64'h0000_0000_0000_005F, 3, 1'b0);
        check_word("R8", r_data[31:0], 32'h407C_0000);
        apply(64'h0000_0000_0000_00FF, 0, 1'b0);
        check_word("R9", r_data[31:0], 32'hFFC0_0000);
        apply(64'h0000_0000_0000_0080, 2, 1'b1);
        check_word("R4", r_data[31:0], 32'h8000_0000);

        // R12: hold while idle
        in_valid = 1'b0;
        in_data = ~in_data;
        @(negedge clk);
        check_set("hold R12", r_data, r_nan, r_inf, r_zero, r_sub);
        checks++;
        if (r_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12 idle out_valid=%b exp=0", r_valid);
        end

        // exhaustive sweep of every code, every format, both range settings
        for (int f = 0; f < 4; f++)
            for (int x = 0; x < 2; x++)
                for (int base = 0; base < 32; base++) begin
                    logic [63:0] w;
                    for (int l = 0; l < LN; l++) w[l*8 +: 8] = 8'(base * 8 + l);
                    apply(w, f, x[0]);
                end

        // seeded random words
        for (int n = 0; n < 400; n++) begin
            logic [63:0] w;
            w = {$urandom, $urandom};
            apply(w, int'($urandom % 4), bit'($urandom % 2));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule